// File: doc/BRIEF.md
# Banked Dual Stack Pointer Register

This block holds the two 32-bit stack pointers of a processor core. The two physical registers are not bound to supervisor or user roles: one is always the active pointer, the one that ordinary register-file reads and writes see. The other is the alternate. When the supervisor bit changes and dual-pointer operation is enabled, the two contents are exchanged in one clock. As a result, the active register always holds the stack of the current mode and the alternate holds the stack of the other mode.

Supervisor code reaches the user pointer through a privileged port. In supervisor mode a user-pointer access resolves to the alternate register. A debug port reads and writes either physical register directly, with no mode translation applied. The dual-pointer enable resets to zero. While it is clear the block behaves as a single legacy stack pointer: mode changes are recorded but never exchange the registers.

Top module: `bankedStackPtr`

## Requirements
- R1: A synchronous reset sets both registers to 0, sets the supervisor bit to 1 and clears the dual-pointer enable.
- R2: A register-file write (`spWrEn`) loads `spWrData` into the active register on the next clock edge. `spRdData` always shows the active register.
- R3: When the enable is set, a `modeLoad` whose `modeNext` differs from the current supervisor bit exchanges the active and alternate contents on that same clock edge.
- R4: When the enable is clear, a `modeLoad` still updates the supervisor bit but leaves both registers where they are.
- R5: In supervisor mode with the enable set, `usrWrEn` loads `usrWrData` into the alternate register. `usrRdData` always shows the alternate register.
- R6: `privFault` is high in the same cycle as any `usrWrEn` or `usrRdEn` made while the supervisor bit is 0 or the enable is clear. A faulted write changes neither register.
- R7: The debug port addresses the physical registers by `dbgSel`, with no mode translation: 0 selects active and 1 selects alternate. `dbgRdData` shows the selected register and `dbgWrEn` writes it.
- R8: When a debug write and a register-file or user-pointer write hit the same register in one cycle, the debug data is stored.
- R9: Writes in a cycle that also exchanges the registers act on the roles before the exchange, and the written value then moves with the exchange.
- R10: A `modeLoad` whose `modeNext` equals the current supervisor bit exchanges nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| modeLoad | input | 1 | Strobe that loads a new supervisor bit |
| modeNext | input | 1 | Supervisor bit value to load |
| enWrEn | input | 1 | Strobe that loads the dual-pointer enable |
| enWrVal | input | 1 | Enable value to load |
| spWrEn | input | 1 | Register-file write of the active pointer |
| spWrData | input | 32 | Register-file write data |
| spRdData | output | 32 | Active pointer |
| usrWrEn | input | 1 | Privileged write of the user pointer |
| usrRdEn | input | 1 | Privileged read of the user pointer |
| usrWrData | input | 32 | Privileged write data |
| usrRdData | output | 32 | Alternate pointer, read as the user pointer |
| privFault | output | 1 | Privilege violation on a user-pointer access |
| dbgWrEn | input | 1 | Debug write strobe |
| dbgSel | input | 1 | Debug target: 0 active, 1 alternate |
| dbgWrData | input | 32 | Debug write data |
| dbgRdData | output | 32 | Debug-selected register |
| supMode | output | 1 | Current supervisor bit |
| dualEn | output | 1 | Current dual-pointer enable |

## Verification
The hardest situation to reach is a single cycle in which a mode change exchanges the registers while writes land on both of them. Reaching it needs the enable already set, supervisor mode held, and a register-file, user-pointer or debug write coinciding with a real mode flip. The stimulus first walks the block into supervisor mode with the enable set. It then raises a register-file write together with a mode change, so the written value can be seen ending up in the alternate register. It also stacks debug writes on top of ordinary writes to the same register, to check which data wins.

// File: rtl/spBankPkg.sv
package spBankPkg;
  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic actWr;       // write active register
    logic actFromDbg;  // active write data comes from the debug port
    logic altWr;       // write alternate register
    logic altFromDbg;  // alternate write data comes from the debug port
    logic swap;        // exchange active and alternate after the writes
  } spStrobe_t;

  localparam logic RESET_MODE = 1'b1;
endpackage

// File: rtl/spBankCtrl.sv
module spBankCtrl
  import spBankPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      modeLoad,
  input  logic      modeNext,
  input  logic      enWrEn,
  input  logic      enWrVal,
  input  logic      spWrEn,
  input  logic      usrWrEn,
  input  logic      usrRdEn,
  input  logic      dbgWrEn,
  input  logic      dbgSel,
  output spStrobe_t st,
  output logic      privFault,
  output logic      supMode,
  output logic      dualEn
);
  logic supReg;
  logic enReg;
  logic usrAllowed;

  assign supMode    = supReg;
  assign dualEn     = enReg;
  assign usrAllowed = supReg & enReg;
  assign privFault  = (usrWrEn | usrRdEn) & ~usrAllowed;

  always_comb begin
    st            = '0;
    st.actFromDbg = dbgWrEn & ~dbgSel;
    st.altFromDbg = dbgWrEn & dbgSel;
    st.actWr      = spWrEn | st.actFromDbg;
    st.altWr      = (usrWrEn & usrAllowed) | st.altFromDbg;
    st.swap       = modeLoad & (modeNext != supReg) & enReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      supReg <= RESET_MODE;
      enReg  <= 1'b0;
    end else begin
      if (modeLoad) supReg <= modeNext;
      if (enWrEn)   enReg  <= enWrVal;
    end
  end

  // R4: legacy operation never exchanges
  a_r4_legacy_no_swap: assert property (@(posedge clk) disable iff (rst)
    !enReg |-> !st.swap);
  // R10: a mode load that repeats the current mode never exchanges
  a_r10_same_mode_no_swap: assert property (@(posedge clk) disable iff (rst)
    (modeLoad && modeNext == supReg) |-> !st.swap);
  // R6: a faulted access never produces a user-pointer write
  a_r6_fault_blocks_write: assert property (@(posedge clk) disable iff (rst)
    privFault |-> (!st.altWr || st.altFromDbg));
  // R8: debug data wins a collision on the active register
  a_r8_dbg_priority: assert property (@(posedge clk) disable iff (rst)
    (dbgWrEn && !dbgSel && spWrEn) |-> st.actFromDbg);
endmodule

// File: rtl/spBankDatapath.sv
module spBankDatapath
  import spBankPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  spStrobe_t    st,
  input  logic [W-1:0] spWrData,
  input  logic [W-1:0] usrWrData,
  input  logic [W-1:0] dbgWrData,
  output logic [W-1:0] actOut,
  output logic [W-1:0] altOut
);
  logic [W-1:0] actReg, altReg;
  logic [W-1:0] actWritten, altWritten;

  assign actOut = actReg;
  assign altOut = altReg;

  // Writes land on the pre-exchange roles
  always_comb begin
    actWritten = actReg;
    altWritten = altReg;
    if (st.actWr) actWritten = st.actFromDbg ? dbgWrData : spWrData;
    if (st.altWr) altWritten = st.altFromDbg ? dbgWrData : usrWrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      actReg <= '0;
      altReg <= '0;
    end else if (st.swap) begin
      actReg <= altWritten;
      altReg <= actWritten;
    end else begin
      actReg <= actWritten;
      altReg <= altWritten;
    end
  end

  // R3: exchange with no writes moves each value to the other role
  a_r3_exchange: assert property (@(posedge clk) disable iff (rst)
    (st.swap && !st.actWr && !st.altWr) |=>
      (actReg == $past(altReg) && altReg == $past(actReg)));
  // R2: a plain register-file write lands in the active register
  a_r2_write_active: assert property (@(posedge clk) disable iff (rst)
    (st.actWr && !st.actFromDbg && !st.swap) |=> actReg == $past(spWrData));
  // R9: a write that coincides with an exchange follows it to the alternate
  a_r9_write_then_swap: assert property (@(posedge clk) disable iff (rst)
    (st.actWr && !st.actFromDbg && st.swap) |=> altReg == $past(spWrData));
endmodule

// File: rtl/bankedStackPtr.sv
module bankedStackPtr
  import spBankPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeLoad,
  input  logic              modeNext,
  input  logic              enWrEn,
  input  logic              enWrVal,
  input  logic              spWrEn,
  input  logic [DATA_W-1:0] spWrData,
  output logic [DATA_W-1:0] spRdData,
  input  logic              usrWrEn,
  input  logic              usrRdEn,
  input  logic [DATA_W-1:0] usrWrData,
  output logic [DATA_W-1:0] usrRdData,
  output logic              privFault,
  input  logic              dbgWrEn,
  input  logic              dbgSel,
  input  logic [DATA_W-1:0] dbgWrData,
  output logic [DATA_W-1:0] dbgRdData,
  output logic              supMode,
  output logic              dualEn
);
  spStrobe_t         strobes;
  logic [DATA_W-1:0] actVal, altVal;

  spBankCtrl u_ctrl (
    .clk(clk), .rst(rst), .modeLoad(modeLoad), .modeNext(modeNext),
    .enWrEn(enWrEn), .enWrVal(enWrVal), .spWrEn(spWrEn),
    .usrWrEn(usrWrEn), .usrRdEn(usrRdEn), .dbgWrEn(dbgWrEn), .dbgSel(dbgSel),
    .st(strobes), .privFault(privFault), .supMode(supMode), .dualEn(dualEn)
  );

  spBankDatapath #(.W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .st(strobes), .spWrData(spWrData),
    .usrWrData(usrWrData), .dbgWrData(dbgWrData),
    .actOut(actVal), .altOut(altVal)
  );

  assign spRdData  = actVal;
  assign usrRdData = altVal;
  assign dbgRdData = dbgSel ? altVal : actVal;
endmodule

// File: tb/tb_bankedStackPtr.sv
module tb_bankedStackPtr;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic modeLoad = 0, modeNext = 0, enWrEn = 0, enWrVal = 0, spWrEn = 0;
  logic usrWrEn = 0, usrRdEn = 0, dbgWrEn = 0, dbgSel = 0;
  logic [W-1:0] spWrData = '0, usrWrData = '0, dbgWrData = '0;
  logic [W-1:0] spRdData, usrRdData, dbgRdData;
  logic privFault, supMode, dualEn;

  always #2.5 clk = ~clk;

  bankedStackPtr dut (.*);

  typedef struct {
    logic [W-1:0] act;
    logic [W-1:0] alt;
    logic         mode;
    logic         en;
    string        tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  logic [W-1:0] mAct = '0, mAlt = '0;
  logic mMode = 1'b1, mEn = 1'b0;
  bit done = 0;

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One cycle of stimulus: the current input signals are applied, the model
  // computes the expected state and pushes it for the monitor.
  task automatic step(input string tag);
    logic fault;
    logic swap;
    logic [W-1:0] nAct, nAlt, tmp;
    expItem_t it;
    #1;
    fault = (usrWrEn | usrRdEn) & ~(mMode & mEn);
    if (!rst) begin
      chk({tag, " privFault"}, {31'd0, privFault}, {31'd0, fault});
      chk({tag, " dbgRdData"}, dbgRdData, dbgSel ? mAlt : mAct);
    end
    nAct = mAct; nAlt = mAlt;
    if (spWrEn) nAct = spWrData;
    if (dbgWrEn && !dbgSel) nAct = dbgWrData;
    if (usrWrEn && !fault) nAlt = usrWrData;
    if (dbgWrEn && dbgSel) nAlt = dbgWrData;
    swap = modeLoad && (modeNext != mMode) && mEn;
    if (swap) begin tmp = nAct; nAct = nAlt; nAlt = tmp; end
    if (modeLoad) mMode = modeNext;
    if (enWrEn) mEn = enWrVal;
    mAct = nAct; mAlt = nAlt;
    if (rst) begin mAct = '0; mAlt = '0; mMode = 1'b1; mEn = 1'b0; end
    it.act = mAct; it.alt = mAlt; it.mode = mMode; it.en = mEn; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    modeLoad = 0; enWrEn = 0; spWrEn = 0; usrWrEn = 0; usrRdEn = 0; dbgWrEn = 0;
    rst = 0;
  endtask

  // Monitor: compares state just after each clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        chk({e.tag, " active"}, spRdData, e.act);
        chk({e.tag, " alternate"}, usrRdData, e.alt);
        chk({e.tag, " mode"}, {31'd0, supMode}, {31'd0, e.mode});
        chk({e.tag, " enable"}, {31'd0, dualEn}, {31'd0, e.en});
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; step("R1 reset");
    enWrEn = 1; enWrVal = 1; step("R1 enable set");
    spWrEn = 1; spWrData = 32'h1111_0000; step("R2 write active");
    modeLoad = 1; modeNext = 0; step("R3 enter user swaps");
    spWrEn = 1; spWrData = 32'h2222_0000; step("R2 user write active");
    usrWrEn = 1; usrWrData = 32'hBAD0_0001; step("R6 user-mode write faults");
    usrRdEn = 1; step("R6 user-mode read faults");
    modeLoad = 1; modeNext = 1; step("R3 enter supervisor swaps");
    usrWrEn = 1; usrWrData = 32'h3333_0000; step("R5 user pointer write");
    usrRdEn = 1; step("R5 user pointer read");
    dbgSel = 1; step("R7 debug read alternate");
    dbgWrEn = 1; dbgSel = 1; dbgWrData = 32'h4444_0000; step("R7 debug write alternate");
    dbgWrEn = 1; dbgSel = 0; dbgWrData = 32'h5555_0000; step("R7 debug write active");
    dbgWrEn = 1; dbgSel = 0; dbgWrData = 32'h6666_0000;
    spWrEn = 1; spWrData = 32'h7777_0000; step("R8 debug beats register write");
    dbgWrEn = 1; dbgSel = 1; dbgWrData = 32'h8888_0000;
    usrWrEn = 1; usrWrData = 32'h9999_0000; step("R8 debug beats user write");
    spWrEn = 1; spWrData = 32'hAAAA_0000; modeLoad = 1; modeNext = 0;
    step("R9 write with swap");
    modeLoad = 1; modeNext = 0; step("R10 repeat mode");
    modeLoad = 1; modeNext = 1; usrWrEn = 1; usrWrData = 32'hCCCC_0000;
    step("R9 swap with faulted user write");
    enWrEn = 1; enWrVal = 0; step("R4 clear enable");
    modeLoad = 1; modeNext = 0; step("R4 legacy mode change");
    modeLoad = 1; modeNext = 1; step("R4 legacy mode back");
    usrWrEn = 1; usrWrData = 32'hDDDD_0000; step("R6 disabled access faults");
    spWrEn = 1; spWrData = 32'hEEEE_0000; step("R2 legacy write");
    rst = 1; step("R1 reset again");
    step("R1 idle after reset");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule